// File: doc/BRIEF.md
# DMA Channel Status Flag Unit

This block holds the status and interrupt flags of one DMA channel. It watches events from the rest of the channel: the transfer down-counter (its load value and each decrement), the trigger input together with the busy state, the address-window checker, the bus read response, the pattern-match strobe and the buffered-data write path. Each event sets a sticky flag. Software reads the flags through a 32-bit read port and clears them by writing zeros. One interrupt request is formed from a chosen subset of the flags.

The half-way watermark is captured when a transfer is loaded. It is the load count shifted right by one. The half flag fires once per load, on the decrement that brings the counter to that value. The two-bit address fault field accumulates by OR. A low-limit violation gives code 01, a high-limit violation gives code 10, and both together, in any order before a clear, give 11. The buffered-data flag is not sticky. It mirrors the pending state of the write path, one cycle late, and software cannot write it.

Top module: `dma_chan_flags`

## Requirements
- R1: After reset, every bit of `rd_data_o` is 0 and `irq_o` is 0.
- R2: A decrement strobe whose presented count value is 0 sets the done flag at bit 5.
- R3: A load captures half = load count >> 1. The first later decrement whose count equals half sets the half flag at bit 4. Reaching that value again before the next load does not set the flag again.
- R4: A trigger while the channel is busy sets the overrun flag at bit 3. A trigger while the channel is idle sets nothing.
- R5: Address fault field bits 7:6: a low-limit violation sets bit 6 (code 01) and a high-limit violation sets bit 7 (code 10). Both, together or one after the other without a clear between them, read as 11.
- R6: Read-error input bit 0 sets register bit 8. Read-error input bit 1 sets register bit 9.
- R7: The pattern-match strobe sets bit 1.
- R8: Bit 0 shows the buffered-data pending input, registered by one cycle. Writes have no effect on it.
- R9: A register write clears each sticky flag whose bit in the write data is 0 and keeps the flags whose bit is 1. A set event in the same cycle as a clearing write leaves the flag at 1.
- R10: Bit 2 and bits 31:10 always read 0, even after a write of all ones.
- R11: `irq_o` is the OR of done AND en[0], half AND en[1], overrun AND en[2], and (any of bits 9:6) AND en[3]. The match flag and the buffer flag never drive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Transfer loaded this cycle |
| load_count_i | input | CNT_W | Start count of the loaded transfer |
| dec_i | input | 1 | Counter decremented this cycle |
| count_i | input | CNT_W | Counter value after the decrement |
| trigger_i | input | 1 | New transfer trigger |
| busy_i | input | 1 | Channel still working on the previous trigger |
| addr_lo_fault_i | input | 1 | Access below the low address limit |
| addr_hi_fault_i | input | 1 | Access above the high address limit |
| rd_err_i | input | 2 | Bus read returned an error (two sources) |
| match_i | input | 1 | Pattern-match detected |
| buf_pending_i | input | 1 | Buffered data word not yet stored |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | REG_W | Write data (0 clears a flag) |
| irq_en_i | input | 4 | Interrupt enables: done, half, overrun, fault |
| rd_data_o | output | REG_W | Flag register read value |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the half watermark, because it depends on state captured at load. The bench has to show that the half flag fires exactly once, at the captured value, for even and odd start counts and for a start count of one, where half and done fire on the same decrement. To do this it loads a transfer and then walks the counter down step by step. It clears the half flag partway through and confirms the flag does not return. A second hard case is a clearing write landing in the same cycle as a set event. The bench drives both at the same edge to check that the set wins.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int FLAG_W  = 10;
    localparam int B_BUF   = 0;
    localparam int B_MATCH = 1;
    localparam int B_OVR   = 3;
    localparam int B_HALF  = 4;
    localparam int B_DONE  = 5;
    localparam int B_FLO   = 6;
    localparam int B_FHI   = 7;
    localparam int B_ERR0  = 8;
    localparam int B_ERR1  = 9;
    localparam int IRQ_W   = 4;
    // bits held as sticky hardware-set / software-clear flags
    localparam logic [FLAG_W-1:0] STICKY_MASK = 10'b11_1111_1010;
endpackage

// File: rtl/dcf_watermark.sv
module dcf_watermark #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_count_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             half_ev_o,
    output logic             done_ev_o
);
    typedef struct packed {
        logic [CNT_W-1:0] half;
        logic             armed;
    } wm_state_t;

    wm_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        half_ev_o = 1'b0;
        done_ev_o = 1'b0;
        if (load_i) begin
            st_d.half  = load_count_i >> 1;
            st_d.armed = 1'b1;
        end else if (dec_i) begin
            done_ev_o = (count_i == '0);
            if (st_q.armed && (count_i == st_q.half)) begin
                half_ev_o  = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the watermark fires once per load
    p_half_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        half_ev_o |=> !half_ev_o);
endmodule

// File: rtl/dcf_flag_bank.sv
module dcf_flag_bank #(
    parameter int              W    = 10,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] flags_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } fb_state_t;

    fb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            if (MASK[i]) begin
                st_d.flags[i] = (wr_en_i ? (st_q.flags[i] & wr_data_i[i])
                                         : st_q.flags[i]) | set_i[i];
            end else begin
                st_d.flags[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    for (genvar g = 0; g < W; g++) begin : g_chk
        if (MASK[g]) begin : g_sticky
            // R9: a set event always leaves the flag at 1
            p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[g] |=> flags_o[g]);
            // R9: without set or clearing write the flag holds
            p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!set_i[g] && !(wr_en_i && !wr_data_i[g]))
                |=> flags_o[g] == $past(flags_o[g]));
        end else begin : g_zero
            // R10: non-sticky positions stay at 0
            p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !flags_o[g]);
        end
    end
endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags #(
    parameter int CNT_W = 32,
    parameter int REG_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [CNT_W-1:0]         load_count_i,
    input  logic                     dec_i,
    input  logic [CNT_W-1:0]         count_i,
    input  logic                     trigger_i,
    input  logic                     busy_i,
    input  logic                     addr_lo_fault_i,
    input  logic                     addr_hi_fault_i,
    input  logic [1:0]               rd_err_i,
    input  logic                     match_i,
    input  logic                     buf_pending_i,
    input  logic                     wr_en_i,
    input  logic [REG_W-1:0]         wr_data_i,
    input  logic [dcf_pkg::IRQ_W-1:0] irq_en_i,
    output logic [REG_W-1:0]         rd_data_o,
    output logic                     irq_o
);
    import dcf_pkg::*;

    typedef struct packed {
        logic buf_pend;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              half_ev, done_ev;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags;
    logic [IRQ_W-1:0]  irq_src;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^wr_data_i[REG_W-1:FLAG_W];

    dcf_watermark #(.CNT_W(CNT_W)) u_wm (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .load_count_i (load_count_i),
        .dec_i        (dec_i),
        .count_i      (count_i),
        .half_ev_o    (half_ev),
        .done_ev_o    (done_ev)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[B_MATCH] = match_i;
        set_vec[B_OVR]   = trigger_i && busy_i;
        set_vec[B_HALF]  = half_ev;
        set_vec[B_DONE]  = done_ev;
        set_vec[B_FLO]   = addr_lo_fault_i;
        set_vec[B_FHI]   = addr_hi_fault_i;
        set_vec[B_ERR0]  = rd_err_i[0];
        set_vec[B_ERR1]  = rd_err_i[1];
    end

    dcf_flag_bank #(.W(FLAG_W), .MASK(STICKY_MASK)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i[FLAG_W-1:0]),
        .flags_o   (flags)
    );

    always_comb begin
        st_d          = st_q;
        st_d.buf_pend = buf_pending_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o             = '0;
        rd_data_o[FLAG_W-1:1] = flags[FLAG_W-1:1];
        rd_data_o[B_BUF]      = st_q.buf_pend;
    end

    assign irq_src = {|flags[B_ERR1:B_FLO], flags[B_OVR], flags[B_HALF], flags[B_DONE]};
    assign irq_o   = |(irq_src & irq_en_i);

    // R4: busy trigger is recorded
    p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger_i && busy_i) |=> rd_data_o[B_OVR]);
    // R10: reserved bits read zero
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[2] && (rd_data_o[REG_W-1:FLAG_W] == '0));
    // R11: an interrupt needs a qualifying flag
    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (rd_data_o[B_DONE:B_OVR] != '0) || (rd_data_o[B_ERR1:B_FLO] != '0));
    // R2: decrement to zero is recorded
    p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && count_i == '0) |=> rd_data_o[B_DONE]);
endmodule

// File: tb/dma_chan_flags_test.sv
module dma_chan_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] load_count_i = '0;
    logic        dec_i = 1'b0;
    logic [31:0] count_i = '0;
    logic        trigger_i = 1'b0, busy_i = 1'b0;
    logic        addr_lo_fault_i = 1'b0, addr_hi_fault_i = 1'b0;
    logic [1:0]  rd_err_i = '0;
    logic        match_i = 1'b0, buf_pending_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  irq_en_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_chan_flags uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_count_i(load_count_i),
        .dec_i(dec_i), .count_i(count_i), .trigger_i(trigger_i), .busy_i(busy_i),
        .addr_lo_fault_i(addr_lo_fault_i), .addr_hi_fault_i(addr_hi_fault_i),
        .rd_err_i(rd_err_i), .match_i(match_i), .buf_pending_i(buf_pending_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .irq_en_i(irq_en_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    // {trig, busy, lo, hi, err[1:0], match, expected[9:0]}
    localparam logic [16:0] VEC [10] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 10'h000},
        {1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 10'h008},
        {1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 10'h000},
        {1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 10'h040},
        {1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 10'h080},
        {1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 10'h0C0},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 10'h100},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 10'h200},
        {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 10'h002},
        {1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 10'h30A}
    };

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic ev(input logic tr, input logic bz, input logic lo, input logic hi,
                      input logic [1:0] er, input logic mt);
        @(negedge clk);
        trigger_i = tr; busy_i = bz; addr_lo_fault_i = lo; addr_hi_fault_i = hi;
        rd_err_i = er; match_i = mt;
        @(negedge clk);
        trigger_i = 1'b0; busy_i = 1'b0; addr_lo_fault_i = 1'b0; addr_hi_fault_i = 1'b0;
        rd_err_i = '0; match_i = 1'b0;
    endtask

    task automatic load(input logic [31:0] n);
        @(negedge clk);
        load_i = 1'b1; load_count_i = n;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic dec(input logic [31:0] v);
        @(negedge clk);
        dec_i = 1'b1; count_i = v;
        @(negedge clk);
        dec_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset read", rd_data_o, 32'h0);
        check("R1 reset irq", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", rd_data_o, 32'h0);

        // table walk: R4 R5 R6 R7 R10
        for (int i = 0; i < 10; i++) begin
            wr(32'h0);
            ev(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:11], VEC[i][10]);
            check($sformatf("R4 R5 R6 R7 R10 vector %0d", i), rd_data_o, {22'h0, VEC[i][9:0]});
        end
        wr(32'h0);

        // R3 / R2 even start count
        load(32'd10);
        for (int v = 9; v >= 6; v--) dec(v);
        check("R3 before half", rd_data_o, 32'h0);
        dec(32'd5);
        check("R3 half at 5", rd_data_o, 32'h010);
        wr(~32'h10);
        check("R9 clear half", rd_data_o, 32'h0);
        for (int v = 4; v >= 1; v--) dec(v);
        check("R3 half only once", rd_data_o, 32'h0);
        dec(32'd0);
        check("R2 done at zero", rd_data_o, 32'h020);

        // R11 enables
        @(negedge clk); irq_en_i = 4'b0000; #1;
        check("R11 done disabled", {31'h0, irq_o}, 32'h0);
        @(negedge clk); irq_en_i = 4'b0001; #1;
        check("R11 done enabled", {31'h0, irq_o}, 32'h1);
        @(negedge clk); irq_en_i = 4'b0010; #1;
        check("R11 half enable only", {31'h0, irq_o}, 32'h0);
        wr(32'hFFFF_FFFF);
        check("R9 write ones keeps", rd_data_o, 32'h020);
        wr(32'h0);
        check("R9 write zero clears", rd_data_o, 32'h0);

        // R3 odd and unit start counts
        load(32'd7);
        for (int v = 6; v >= 4; v--) dec(v);
        check("R3 odd before", rd_data_o, 32'h0);
        dec(32'd3);
        check("R3 odd half at 3", rd_data_o, 32'h010);
        wr(32'h0);
        load(32'd1);
        dec(32'd0);
        check("R2 R3 unit count", rd_data_o, 32'h030);
        wr(32'h0);

        // R5 accumulate then partial clear
        ev(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
        check("R5 low code", rd_data_o, 32'h040);
        ev(1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0);
        check("R5 combined code", rd_data_o, 32'h0C0);
        wr(~32'h40);
        check("R9 partial clear", rd_data_o, 32'h080);
        @(negedge clk); irq_en_i = 4'b1000; #1;
        check("R11 fault enabled", {31'h0, irq_o}, 32'h1);
        @(negedge clk); irq_en_i = 4'b0111; #1;
        check("R11 fault disabled", {31'h0, irq_o}, 32'h0);
        wr(32'h0);

        ev(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
        @(negedge clk); irq_en_i = 4'b1111; #1;
        check("R11 match not a source", {31'h0, irq_o}, 32'h0);
        check("R7 match set", rd_data_o, 32'h002);
        wr(32'h0);

        // R9 set wins over clear
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = 32'h0; trigger_i = 1'b1; busy_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; trigger_i = 1'b0; busy_i = 1'b0;
        check("R9 set beats clear", rd_data_o, 32'h008);
        wr(32'h0);

        // R8 buffer flag
        @(negedge clk); buf_pending_i = 1'b1;
        @(negedge clk);
        check("R8 pending shown", rd_data_o, 32'h001);
        wr(32'h0);
        check("R8 write ignored", rd_data_o, 32'h001);
        buf_pending_i = 1'b0;
        @(negedge clk);
        check("R8 pending gone", rd_data_o, 32'h0);

        // R10 reserved bits
        wr(32'hFFFF_FFFF);
        check("R10 ones write", rd_data_o, 32'h0);

        summary();
        $finish;
    end
endmodule